// File: doc/BRIEF.md
# Trigger Validation Latency Timer

This block sits after the post-trigger delay of a sampling front end. When validated triggering is on, it keeps the frozen sample memory on hold and opens a validation window. The window is a programmable number of coarse ticks. A coarse tick is one period of a prescaled clock, 2.5 µs at either pilot clock rate.

If a rising edge arrives on the shared enable/validation input inside the window, the block requests conversion. If no edge arrives, the block tells the sampler to resume writing. It then keeps the trigger disabled for a second programmable re-arm delay, so the memory can refill.

When validated triggering is off, the shared input acts as a plain trigger gate. Each post-trigger completion then goes straight to conversion.

The controller is a three-state machine:

- **ARMED**: trigger enabled, waiting for the post-trigger completion.
- **WINDOW**: trigger disabled, waiting for validation.
- **REARM**: trigger disabled, memory refilling.

It has five named transitions:

- **START**: ARMED to WINDOW. Loads the window count.
- **BYPASS**: ARMED stays ARMED, used when the mode is off. Conversion is requested immediately.
- **ACCEPT**: WINDOW to ARMED.
- **REJECT**: WINDOW to REARM. Loads the re-arm count.
- **REARMED**: REARM to ARMED.

A 2.5 µs tick counter (the prescaler) is restarted on every load. A shared down counter measures both delays.

Top module: `trig_valid_timer`

## Requirements
- R1: During and right after reset the state is ARMED. `conv_req`, `resume`, `acc_pulse` and `rej_pulse` are all 0, and `trig_en` is 1 when `mode_en` is 1.
- R2: With `mode_en`=1, `trig_en` is 1 only in ARMED and ignores `gate_in`. It is 0 from the clock edge that samples `ptrig_done` until the block is re-armed.
- R3: With `mode_en`=0, `trig_en` equals `gate_in`. A `ptrig_done` pulse gives a one-cycle `conv_req` after the sampling edge, with no `acc_pulse` and no `rej_pulse`.
- R4: Let N = `win_lat` and D = the tick division, and number the edges after START as 1, 2, and so on. A validation rising edge first seen at edge k, with 1 ≤ k ≤ N·D, raises `conv_req` and `acc_pulse` together for one cycle after edge k, and `trig_en` rises at that same edge.
- R5: If no validation edge is seen at edges 1..N·D, then after edge N·D+1 `resume` and `rej_pulse` are high together for one cycle. A validation edge first seen at edge N·D+1 itself loses to the timeout. `conv_req` and `resume` are never high in the same cycle.
- R6: `win_lat` = 0 gives an immediate timeout: the reject pulses follow edge 1 and no validation is accepted.
- R7: After the reject pulse edge, `trig_en` returns to 1 exactly M·D+1 edges later, where M = max(`rearm_lat`, 1). A re-arm value of 0 therefore behaves as 1.
- R8: D equals parameter `DIV_HI` (default 250) when `freq_sel`=1, and `DIV_LO` (default 125) when `freq_sel`=0. The prescaler restarts at every START and REJECT.
- R9: Validation edges outside the window are ignored: during REARM they produce no `acc_pulse` and no `conv_req`. An input that is already high when the window opens, with no new rising edge, is never accepted.
- R10: A `ptrig_done` pulse that arrives while the block is in WINDOW is ignored and does not change when the reject occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pilot-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Validated-trigger mode enable |
| freq_sel | input | 1 | 1 selects the fast pilot clock division, 0 the slow one |
| ptrig_done | input | 1 | One-cycle pulse at the end of the post-trigger delay |
| gate_in | input | 1 | Synchronised shared input: trigger gate when the mode is off, validation when it is on |
| win_lat | input | LAT_W | Validation window length in ticks |
| rearm_lat | input | LAT_W | Re-arm delay in ticks, with 0 treated as 1 |
| conv_req | output | 1 | One-cycle conversion request |
| resume | output | 1 | One-cycle pulse telling the sampler to resume writing |
| trig_en | output | 1 | Trigger enable level |
| acc_pulse | output | 1 | One-cycle pulse: trigger validated |
| rej_pulse | output | 1 | One-cycle pulse: trigger rejected |

## Verification
A window counter loaded with the wrong value, or a prescaler that is not restarted, shows at the ports as reject pulses or accept cut-offs that move by whole ticks. These become visible within one window of the START edge. A state machine stuck outside ARMED holds `trig_en` low past the predicted re-arm edge, which gives a mismatch only M·D+1 cycles after the reject. The bench sweeps window and re-arm lengths, both division settings, and validation edge positions at and around each window boundary. It predicts every pulse edge from N, M and D.

// File: rtl/tvt_pkg.sv
package tvt_pkg;

    typedef enum logic [1:0] {
        S_ARMED  = 2'd0,
        S_WINDOW = 2'd1,
        S_REARM  = 2'd2
    } tvt_state_e;

    typedef enum logic [2:0] {
        T_NONE     = 3'd0,
        T_START    = 3'd1,
        T_BYPASS   = 3'd2,
        T_ACCEPT   = 3'd3,
        T_REJECT   = 3'd4,
        T_REARMED  = 3'd5
    } tvt_trans_e;

endpackage

// File: rtl/tvt_tick.sv
// Coarse tick prescaler: one tick every DIV_HI or DIV_LO cycles while running.
module tvt_tick #(
    parameter int DIV_HI = 250,
    parameter int DIV_LO = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic sel,
    output logic tick
);
    localparam int MAXD = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    assign lim_m1 = sel ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    assign tick   = run && (cnt_q == lim_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tvt_lat_cnt.sv
// Shared tick down-counter for the validation window and the re-arm delay.
module tvt_lat_cnt #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [LAT_W-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && !zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/tvt_fsm.sv
// Validation controller: ARMED -> WINDOW -> (ARMED | REARM -> ARMED).
module tvt_fsm
    import tvt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_en,
    input  logic       ptrig_done,
    input  logic       vrise,
    input  logic       lat_zero,
    output tvt_state_e st,
    output logic       ld,
    output logic       ld_rearm,
    output logic       conv_req,
    output logic       resume,
    output logic       acc,
    output logic       rej
);
    tvt_state_e nxt;
    tvt_trans_e tr;

    always_comb begin
        nxt      = st;
        ld       = 1'b0;
        ld_rearm = 1'b0;
        tr       = T_NONE;
        unique case (st)
            S_ARMED: begin
                if (ptrig_done) begin
                    if (mode_en) begin
                        nxt = S_WINDOW;
                        ld  = 1'b1;
                        tr  = T_START;
                    end else begin
                        tr  = T_BYPASS;
                    end
                end
            end
            S_WINDOW: begin
                if (lat_zero) begin
                    nxt      = S_REARM;
                    ld       = 1'b1;
                    ld_rearm = 1'b1;
                    tr       = T_REJECT;
                end else if (vrise) begin
                    nxt = S_ARMED;
                    tr  = T_ACCEPT;
                end
            end
            S_REARM: begin
                if (lat_zero) begin
                    nxt = S_ARMED;
                    tr  = T_REARMED;
                end
            end
            default: begin
                nxt = S_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_ARMED;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_req <= 1'b0;
            resume   <= 1'b0;
            acc      <= 1'b0;
            rej      <= 1'b0;
        end else begin
            conv_req <= (tr == T_ACCEPT) || (tr == T_BYPASS);
            resume   <= (tr == T_REJECT);
            acc      <= (tr == T_ACCEPT);
            rej      <= (tr == T_REJECT);
        end
    end
endmodule

// File: rtl/trig_valid_timer.sv
module trig_valid_timer
    import tvt_pkg::*;
#(
    parameter int DIV_HI = 250,
    parameter int DIV_LO = 125,
    parameter int LAT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             freq_sel,
    input  logic             ptrig_done,
    input  logic             gate_in,
    input  logic [LAT_W-1:0] win_lat,
    input  logic [LAT_W-1:0] rearm_lat,
    output logic             conv_req,
    output logic             resume,
    output logic             trig_en,
    output logic             acc_pulse,
    output logic             rej_pulse
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    tvt_state_e       st;
    logic             gate_q;
    logic             vrise;
    logic             tick;
    logic             lat_zero;
    logic             ld;
    logic             ld_rearm;
    logic [LAT_W-1:0] rearm_eff;
    logic [LAT_W-1:0] ld_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_in;
        end
    end

    assign vrise     = gate_in && !gate_q;
    assign rearm_eff = (rearm_lat == '0) ? ONE : rearm_lat;
    assign ld_val    = ld_rearm ? rearm_eff : win_lat;
    assign trig_en   = mode_en ? (st == S_ARMED) : gate_in;

    tvt_tick #(
        .DIV_HI (DIV_HI),
        .DIV_LO (DIV_LO)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ld),
        .run   ((st == S_WINDOW) || (st == S_REARM)),
        .sel   (freq_sel),
        .tick  (tick)
    );

    tvt_lat_cnt #(
        .LAT_W (LAT_W)
    ) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .dec      (tick),
        .zero     (lat_zero)
    );

    tvt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .ptrig_done (ptrig_done),
        .vrise      (vrise),
        .lat_zero   (lat_zero),
        .st         (st),
        .ld         (ld),
        .ld_rearm   (ld_rearm),
        .conv_req   (conv_req),
        .resume     (resume),
        .acc        (acc_pulse),
        .rej        (rej_pulse)
    );
endmodule

// File: rtl/tvt_chk.sv
module tvt_chk
    import tvt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mode_en,
    input tvt_state_e st,
    input logic       lat_zero,
    input logic       tick,
    input logic       conv_req,
    input logic       resume,
    input logic       acc,
    input logic       rej,
    input logic       trig_en
);
    // R5: conversion and resume never coincide
    p_conv_resume_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_req && resume));

    // R4: an accept always carries a conversion request
    p_accept_converts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> conv_req);

    // R2: trigger held off while the window is open
    p_window_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && st == S_WINDOW) |-> !trig_en);

    // R6: an exhausted window count rejects on the next edge
    p_zero_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WINDOW && lat_zero) |=> (rej && st == S_REARM));

    // R7: re-arm delay lasts at least one tick, so trigger stays off next cycle
    p_rearm_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && rej) |=> !trig_en);

    // R8: prescaler never ticks on consecutive cycles
    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5: accept and reject are mutually exclusive
    p_status_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc, rej}));
endmodule

bind trig_valid_timer tvt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_en  (mode_en),
    .st       (st),
    .lat_zero (lat_zero),
    .tick     (tick),
    .conv_req (conv_req),
    .resume   (resume),
    .acc      (acc_pulse),
    .rej      (rej_pulse),
    .trig_en  (trig_en)
);

// File: tb/sim_trig_valid_timer.sv
`timescale 1ns/1ps
module sim_trig_valid_timer;
    localparam int DHI = 4;
    localparam int DLO = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b1;
    logic       freq_sel = 1'b1;
    logic       ptrig_done = 1'b0;
    logic       gate_in = 1'b0;
    logic [7:0] win_lat = 8'd1;
    logic [7:0] rearm_lat = 8'd1;
    logic       conv_req, resume, trig_en, acc_pulse, rej_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_valid_timer #(.DIV_HI(DHI), .DIV_LO(DLO), .LAT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .freq_sel(freq_sel),
        .ptrig_done(ptrig_done), .gate_in(gate_in), .win_lat(win_lat),
        .rearm_lat(rearm_lat), .conv_req(conv_req), .resume(resume),
        .trig_en(trig_en), .acc_pulse(acc_pulse), .rej_pulse(rej_pulse)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // vk: edge at which validation first rises (0 = never, -1 = already high)
    // ptk: edge at which a stray ptrig_done is driven (0 = none)
    task automatic run_case(input int n, input int m, input logic sel,
                            input int vk, input int ptk);
        int d, nd, mm, exp_k, got_k, r;
        bit exp_acc;
        logic g_acc, g_rej, g_conv, g_res;
        d = sel ? DHI : DLO;
        nd = n * d;
        mm = (m == 0) ? 1 : m;
        exp_acc = (vk >= 1) && (vk <= nd);
        exp_k = exp_acc ? vk : nd + 1;
        got_k = -1; g_acc = 0; g_rej = 0; g_conv = 0; g_res = 0;
        @(negedge clk);
        win_lat = 8'(n); rearm_lat = 8'(m); freq_sel = sel; mode_en = 1'b1;
        gate_in = (vk < 0);
        @(negedge clk);
        gate_in = (vk < 0) ? 1'b1 : 1'b0;
        chk("R2 armed trig_en", int'(trig_en), 1);
        ptrig_done = 1'b1;
        @(posedge clk); #1;
        ptrig_done = 1'b0;
        chk("R2 trig_en off after start", int'(trig_en), 0);
        for (int k = 1; k <= nd + 3; k++) begin
            @(negedge clk);
            if (k == vk) gate_in = 1'b1;
            ptrig_done = (k == ptk);
            @(posedge clk); #1;
            ptrig_done = 1'b0;
            if (acc_pulse || rej_pulse || conv_req || resume) begin
                got_k = k; g_acc = acc_pulse; g_rej = rej_pulse;
                g_conv = conv_req; g_res = resume;
                break;
            end
        end
        if (n == 0) chk("R6 zero window decision edge", got_k, 1);
        if (ptk != 0) chk("R10 stray ptrig_done decision edge", got_k, exp_k);
        if (vk < 0) chk("R9 held level not accepted", int'(g_acc), 0);
        chk(exp_acc ? "R4 decision edge" : "R5 decision edge", got_k, exp_k);
        chk("R4 acc_pulse", int'(g_acc), int'(exp_acc));
        chk("R4 conv_req", int'(g_conv), int'(exp_acc));
        chk("R5 rej_pulse", int'(g_rej), int'(!exp_acc));
        chk("R5 resume", int'(g_res), int'(!exp_acc));
        if (exp_acc) begin
            chk("R4 trig_en back on accept", int'(trig_en), 1);
        end else begin
            r = -1;
            for (int j = 1; j <= mm * d + 3; j++) begin
                @(negedge clk);
                if (j == 1) gate_in = 1'b0;
                if (j == 2) gate_in = 1'b1;
                @(posedge clk); #1;
                if (acc_pulse || conv_req) chk("R9 edge in rearm ignored", 1, 0);
                if (trig_en) begin
                    r = j;
                    break;
                end
            end
            chk("R7 rearm edge count", r, mm * d + 1);
        end
        @(negedge clk);
        gate_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset trig_en", int'(trig_en), 1);
        chk("R1 reset pulses", int'({conv_req, resume, acc_pulse, rej_pulse}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset trig_en", int'(trig_en), 1);
        chk("R1 after reset pulses", int'({conv_req, resume, acc_pulse, rej_pulse}), 0);

        // R3: mode off, gate passes through, bypass conversion
        mode_en = 1'b0;
        gate_in = 1'b0;
        @(negedge clk);
        chk("R3 trig_en follows gate low", int'(trig_en), 0);
        gate_in = 1'b1;
        #1;
        chk("R3 trig_en follows gate high", int'(trig_en), 1);
        gate_in = 1'b0;
        ptrig_done = 1'b1;
        @(posedge clk); #1;
        ptrig_done = 1'b0;
        chk("R3 bypass conv_req", int'(conv_req), 1);
        chk("R3 bypass no status", int'({acc_pulse, rej_pulse}), 0);
        @(posedge clk); #1;
        chk("R3 conv_req single cycle", int'(conv_req), 0);

        // R2: gate ignored in mode on
        @(negedge clk);
        mode_en = 1'b1;
        gate_in = 1'b0;
        #1;
        chk("R2 gate ignored in mode", int'(trig_en), 1);

        // R8 sweep: both division settings, window lengths, edge positions
        for (int s = 0; s <= 1; s++) begin
            for (int n = 0; n <= 3; n++) begin
                for (int m = 0; m <= 2; m++) begin
                    int d;
                    d = (s == 1) ? DHI : DLO;
                    run_case(n, m, logic'(s), 0, 0);
                    if (n > 0) begin
                        run_case(n, m, logic'(s), 1, 0);
                        run_case(n, m, logic'(s), n * d, 0);
                        run_case(n, m, logic'(s), n * d + 1, 0);
                        run_case(n, m, logic'(s), 2, 0);
                    end else begin
                        run_case(n, m, logic'(s), 1, 0);
                    end
                end
            end
        end
        run_case(2, 1, 1'b1, -1, 0);
        run_case(2, 1, 1'b0, 0, 2);
        run_case(3, 2, 1'b1, 9, 4);
        run_case(255, 3, 1'b1, 1000, 0);
        summary();
    end
endmodule